// File: doc/BRIEF.md
# Paged memory window controller

This block sits on a slow expansion bus that exposes two 256-location I/O pages, each selected by its own active-low strobe. It turns the second page into a movable 256-byte window onto an external RAM of up to 64KB. The high byte of every RAM address comes from an 8-bit page register, and the low byte comes straight from the bus. The first page holds the control locations: the page register at offset 0xFF and an enable latch at offset 0xFE.

The page register is write-only. Host software has to keep its own copy of the value it last wrote, for example so that an interrupt handler can put the page back. Three build-time options change the map. The page register can also appear at offset 0xFF of the window page. The top two window offsets can be kept away from RAM, because they hold test-software vectors. Page numbers can be confined to the upper half of the RAM.

All logic runs on a fast system clock, and the bus clock is an input that this clock samples. Register loads happen on a sampled falling edge of the bus clock during a write cycle. The RAM strobes and the read-data gate are combinational from the bus pins and the register state.

Top module: `pgwin_ctrl`

## Requirements
- R1: After reset, the page register reads as zero on `ram_addr[15:8]` and the window is disabled, so a window access leaves `ram_cs_n` high.
- R2: A write (`rnw`=0) with `sel_a_n` low and `addr_lo`=0xFF loads `data_in` into the page register on a falling edge of `bus_clk`. From the next system clock on, the value is visible as `ram_addr[15:8]`.
- R3: A read (`rnw`=1) of the page-register location never drives the bus: `data_oe` stays 0 and `data_out` stays 0.
- R4: While the window is enabled, an access with only `sel_b_n` low to a RAM-mapped offset pulls `ram_cs_n` low, and `ram_addr` equals {page register, `addr_lo`}.
- R5: A write with `sel_a_n` low and `addr_lo`=0xFE loads bit 0 of `data_in` into the enable latch (1 = enabled). While the latch is 0, `ram_cs_n` and `ram_we_n` stay high and `data_oe` stays 0.
- R6: `ram_we_n` is low only while `bus_clk` is high during a window write that selects RAM.
- R7: `data_oe` is 1 and `data_out` equals `ram_rdata` only while `bus_clk` is high, `rnw` is 1, the window is enabled and the address decodes to RAM. Otherwise `data_out` is 0.
- R8: With `MIRROR_EN`=1, window offset 0xFF acts as the page register: a write there loads it, and that offset never selects RAM.
- R9: With `RESV_EN`=1, window offsets 0xFE and 0xFF (0xFE only, when the mirror takes 0xFF) keep `ram_cs_n` high and do not drive the bus. With `RESV_EN`=0 they are ordinary RAM.
- R10: With `UPPER_ONLY`=1, every page-register load sets bit 7 of the page (0x12 becomes 0x92).
- R11: The registers change only on a sampled falling edge of `bus_clk` with `rnw` low. Reads and the high phase of a write leave them unchanged.
- R12: When both strobes are low at once, the first page (`sel_a_n`) takes precedence.
- R13: Writes to first-page offsets other than 0xFE and 0xFF change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Expansion bus clock; registers load on its falling edge |
| rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| sel_a_n | input | 1 | Active-low select of the control page |
| sel_b_n | input | 1 | Active-low select of the window page |
| addr_lo | input | 8 | Low byte of the bus address |
| data_in | input | 8 | Data the host writes |
| data_out | output | 8 | Read data toward the host (0 when not driven) |
| data_oe | output | 1 | Output enable for `data_out` onto the bus |
| ram_addr | output | 16 | RAM address, {page, `addr_lo`} |
| ram_cs_n | output | 1 | Active-low RAM chip select |
| ram_we_n | output | 1 | Active-low RAM write strobe |
| ram_wdata | output | 8 | Write data toward RAM |
| ram_rdata | input | 8 | Read data from RAM |

## Verification
The hardest case to reach from the ports is an access where the build options overlap. Offset 0xFF of the window page is claimed both by the mirror and by the reserved-vector exclusion, and page-register loads also pass through the upper-half restriction. The bench therefore runs two instances side by side on the same bus. One has the mirror and the reservation on. The other has both off and the upper-half restriction on. Directed cycles hit offsets 0xFE/0xFF in both pages and cycles with both strobes low. Random cycles are weighted toward those offsets, so that every register change is seen through `ram_addr[15:8]` and the chip select.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  // Result of address decode for one bus access.
  typedef enum logic [2:0] {
    HIT_NONE = 3'd0,  // no location of this block
    HIT_PAGE = 3'd1,  // page register (control page or window mirror)
    HIT_ENA  = 3'd2,  // window enable latch
    HIT_RAM  = 3'd3,  // window location passed to external RAM
    HIT_RESV = 3'd4   // window location withheld from RAM
  } hit_e;
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
#(
  parameter int unsigned LO_W      = 8,
  parameter bit          MIRROR_EN = 1'b0,
  parameter bit          RESV_EN   = 1'b1
) (
  input  logic            sel_a_n,
  input  logic            sel_b_n,
  input  logic [LO_W-1:0] addr_lo,
  output hit_e            hit
);
  localparam logic [LO_W-1:0] OFS_TOP  = {LO_W{1'b1}};
  localparam logic [LO_W-1:0] OFS_NEXT = OFS_TOP - LO_W'(1);

  logic is_top, is_next, win_top_page, win_resv;

  assign is_top  = (addr_lo == OFS_TOP);
  assign is_next = (addr_lo == OFS_NEXT);

  generate
    if (MIRROR_EN) begin : g_mirror
      assign win_top_page = is_top;
    end else begin : g_no_mirror
      assign win_top_page = 1'b0;
    end
    if (RESV_EN) begin : g_resv
      assign win_resv = is_top | is_next;
    end else begin : g_no_resv
      assign win_resv = 1'b0;
    end
  endgenerate

  always_comb begin
    hit = HIT_NONE;
    if (!sel_a_n) begin
      if (is_top)       hit = HIT_PAGE;
      else if (is_next) hit = HIT_ENA;
    end else if (!sel_b_n) begin
      if (win_top_page)  hit = HIT_PAGE;
      else if (win_resv) hit = HIT_RESV;
      else               hit = HIT_RAM;
    end
  end
endmodule

// File: rtl/pgwin_regs.sv
module pgwin_regs
  import pgwin_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_W     = 8,
  parameter bit          UPPER_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              rnw,
  input  hit_e              hit,
  input  logic [DATA_W-1:0] data_in,
  output logic [PAGE_W-1:0] page,
  output logic              ena,
  output logic              bus_fall
);
  localparam int unsigned TAKE_W = (PAGE_W < DATA_W) ? PAGE_W : DATA_W;

  logic              bus_clk_q;
  logic [PAGE_W-1:0] page_raw, page_next;
  logic              wr_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_clk_q <= 1'b0;
    else        bus_clk_q <= bus_clk;
  end

  assign bus_fall  = bus_clk_q & ~bus_clk;
  assign wr_strobe = bus_fall & ~rnw;

  always_comb begin
    page_raw = '0;
    page_raw[TAKE_W-1:0] = data_in[TAKE_W-1:0];
  end

  generate
    if (UPPER_ONLY) begin : g_upper
      assign page_next = page_raw | (PAGE_W'(1) << (PAGE_W - 1));
    end else begin : g_full
      assign page_next = page_raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
      ena  <= 1'b0;
    end else if (wr_strobe) begin
      if (hit == HIT_PAGE) page <= page_next;
      if (hit == HIT_ENA)  ena  <= data_in[0];
    end
  end
endmodule

// File: rtl/pgwin_ramif.sv
module pgwin_ramif
  import pgwin_pkg::*;
#(
  parameter int unsigned LO_W   = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  hit_e                   hit,
  input  logic [PAGE_W-1:0]      page,
  input  logic [LO_W-1:0]        addr_lo,
  input  logic                   ena,
  input  logic                   bus_clk,
  input  logic                   rnw,
  input  logic [DATA_W-1:0]      data_in,
  input  logic [DATA_W-1:0]      ram_rdata,
  output logic [PAGE_W+LO_W-1:0] ram_addr,
  output logic                   ram_cs_n,
  output logic                   ram_we_n,
  output logic [DATA_W-1:0]      ram_wdata,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_oe
);
  logic ram_sel;

  assign ram_sel   = (hit == HIT_RAM) & ena;
  assign ram_addr  = {page, addr_lo};
  assign ram_cs_n  = ~ram_sel;
  assign ram_we_n  = ~(ram_sel & bus_clk & ~rnw);
  assign ram_wdata = data_in;
  assign data_oe   = ram_sel & bus_clk & rnw;
  assign data_out  = data_oe ? ram_rdata : '0;
endmodule

// File: rtl/pgwin_ctrl.sv
module pgwin_ctrl
  import pgwin_pkg::*;
#(
  parameter int unsigned LO_W       = 8,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter bit          MIRROR_EN  = 1'b0,
  parameter bit          RESV_EN    = 1'b1,
  parameter bit          UPPER_ONLY = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_clk,
  input  logic                   rnw,
  input  logic                   sel_a_n,
  input  logic                   sel_b_n,
  input  logic [LO_W-1:0]        addr_lo,
  input  logic [DATA_W-1:0]      data_in,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_oe,
  output logic [PAGE_W+LO_W-1:0] ram_addr,
  output logic                   ram_cs_n,
  output logic                   ram_we_n,
  output logic [DATA_W-1:0]      ram_wdata,
  input  logic [DATA_W-1:0]      ram_rdata
);
  hit_e              hit;
  logic [PAGE_W-1:0] page;
  logic              ena;
  logic              bus_fall;

  pgwin_decode #(
    .LO_W(LO_W), .MIRROR_EN(MIRROR_EN), .RESV_EN(RESV_EN)
  ) u_decode (
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr_lo(addr_lo), .hit(hit)
  );

  pgwin_regs #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .UPPER_ONLY(UPPER_ONLY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .rnw(rnw), .hit(hit),
    .data_in(data_in), .page(page), .ena(ena), .bus_fall(bus_fall)
  );

  pgwin_ramif #(
    .LO_W(LO_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) u_ramif (
    .hit(hit), .page(page), .addr_lo(addr_lo), .ena(ena),
    .bus_clk(bus_clk), .rnw(rnw), .data_in(data_in),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n), .ram_wdata(ram_wdata), .data_out(data_out),
    .data_oe(data_oe)
  );
endmodule

// File: rtl/pgwin_ctrl_chk.sv
module pgwin_ctrl_chk #(
  parameter int unsigned LO_W       = 8,
  parameter int unsigned PAGE_W     = 8,
  parameter bit          MIRROR_EN  = 1'b0,
  parameter bit          RESV_EN    = 1'b1,
  parameter bit          UPPER_ONLY = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_clk,
  input logic                   rnw,
  input logic                   sel_a_n,
  input logic                   sel_b_n,
  input logic [LO_W-1:0]        addr_lo,
  input logic                   data_oe,
  input logic [PAGE_W+LO_W-1:0] ram_addr,
  input logic                   ram_cs_n,
  input logic                   ram_we_n,
  input logic                   ena,
  input logic                   bus_fall
);
  localparam logic [LO_W-1:0] TOP  = {LO_W{1'b1}};
  localparam logic [LO_W-1:0] NEXT = TOP - LO_W'(1);

  // R6: write strobe only in the high phase of a selected window write
  p_we_high_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (bus_clk && !rnw && !ram_cs_n));

  // R7: bus driven only in the high phase of a selected window read
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (bus_clk && rnw && !ram_cs_n));

  // R3: a read of the page-register location stays off the bus
  p_page_read_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && addr_lo == TOP && rnw) |-> !data_oe);

  // R5: RAM is selected only while the enable latch is set
  p_cs_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> ena);

  // R11: page unchanged unless a falling bus edge during a write
  p_page_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_fall && !rnw) |=> $stable(ram_addr[PAGE_W+LO_W-1:LO_W]));

  // R9: reserved window offsets never select RAM
  p_resv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (RESV_EN && sel_a_n && !sel_b_n && (addr_lo == TOP || addr_lo == NEXT))
      |-> (ram_cs_n && !data_oe));

  // R10: any page load in upper-only mode lands in the upper half
  p_upper_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (UPPER_ONLY && bus_fall && !rnw && !sel_a_n && addr_lo == TOP)
      |=> ram_addr[PAGE_W+LO_W-1]);

  // R8: with the mirror on, window offset 0xFF never selects RAM
  p_mirror_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (MIRROR_EN && sel_a_n && !sel_b_n && addr_lo == TOP) |-> ram_cs_n);
endmodule

bind pgwin_ctrl pgwin_ctrl_chk #(
  .LO_W(LO_W), .PAGE_W(PAGE_W), .MIRROR_EN(MIRROR_EN),
  .RESV_EN(RESV_EN), .UPPER_ONLY(UPPER_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .rnw(rnw),
  .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr_lo(addr_lo),
  .data_oe(data_oe), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
  .ram_we_n(ram_we_n), .ena(ena), .bus_fall(bus_fall)
);

// File: tb/pgwin_ctrl_tb.sv
`timescale 1ns/1ps
module pgwin_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, rnw = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1;
  logic [7:0] addr_lo = 8'h00, data_in = 8'h00, ram_rdata = 8'h00;

  logic [7:0]  dout_a, dout_b, wd_a, wd_b;
  logic        oe_a, oe_b, cs_a, cs_b, we_a, we_b;
  logic [15:0] ra_a, ra_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state: A = mirror+reserve, B = upper-only, no mirror, no reserve
  logic [7:0] pg_a = 8'h00, pg_b = 8'h00;
  logic       en_a = 1'b0, en_b = 1'b0;

  always #2.5 clk = ~clk;

  pgwin_ctrl #(.MIRROR_EN(1'b1), .RESV_EN(1'b1), .UPPER_ONLY(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .rnw(rnw),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr_lo(addr_lo),
    .data_in(data_in), .data_out(dout_a), .data_oe(oe_a),
    .ram_addr(ra_a), .ram_cs_n(cs_a), .ram_we_n(we_a),
    .ram_wdata(wd_a), .ram_rdata(ram_rdata));

  pgwin_ctrl #(.MIRROR_EN(1'b0), .RESV_EN(1'b0), .UPPER_ONLY(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .rnw(rnw),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .addr_lo(addr_lo),
    .data_in(data_in), .data_out(dout_b), .data_oe(oe_b),
    .ram_addr(ra_b), .ram_cs_n(cs_b), .ram_we_n(we_b),
    .ram_wdata(wd_b), .ram_rdata(ram_rdata));

  // 0 none, 1 page, 2 enable, 3 ram, 4 reserved
  function automatic int kind(logic sa_n, logic sb_n, logic [7:0] a,
                              bit mirror, bit resv);
    if (!sa_n) return (a == 8'hFF) ? 1 : (a == 8'hFE) ? 2 : 0;
    if (!sb_n) begin
      if (mirror && a == 8'hFF) return 1;
      if (resv && a >= 8'hFE) return 4;
      return 3;
    end
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one full bus cycle: high phase, then falling edge, then idle
  task automatic bus_cycle(logic sa_n, logic sb_n, logic [7:0] a,
                           logic [7:0] d, logic rd, string req);
    int ka, kb;
    bit sel_ra, sel_rb;
    ka = kind(sa_n, sb_n, a, 1'b1, 1'b1);
    kb = kind(sa_n, sb_n, a, 1'b0, 1'b0);
    @(negedge clk);
    sel_a_n = sa_n; sel_b_n = sb_n; addr_lo = a; data_in = d; rnw = rd;
    ram_rdata = 8'($urandom); bus_clk = 1'b1;
    @(negedge clk);
    sel_ra = (ka == 3) && en_a;
    sel_rb = (kb == 3) && en_b;
    check({req, " R4 addr A"}, ra_a, {pg_a, a});
    check({req, " R4 addr B"}, ra_b, {pg_b, a});
    check({req, " R5 R9 cs A"}, cs_a, !sel_ra);
    check({req, " R5 R9 cs B"}, cs_b, !sel_rb);
    check({req, " R6 we A"}, we_a, !(sel_ra && !rd));
    check({req, " R6 we B"}, we_b, !(sel_rb && !rd));
    check({req, " R7 R3 oe A"}, oe_a, sel_ra && rd);
    check({req, " R7 R3 oe B"}, oe_b, sel_rb && rd);
    check({req, " R7 data A"}, dout_a, (sel_ra && rd) ? ram_rdata : 8'h00);
    check({req, " R7 data B"}, dout_b, (sel_rb && rd) ? ram_rdata : 8'h00);
    @(negedge clk);
    bus_clk = 1'b0;
    #1;
    check({req, " R6 we low phase"}, {we_a, we_b}, 2'b11);
    check({req, " R7 oe low phase"}, {oe_a, oe_b}, 2'b00);
    @(negedge clk);
    if (!rd) begin
      if (ka == 1) pg_a = d;
      if (ka == 2) en_a = d[0];
      if (kb == 1) pg_b = d | 8'h80;
      if (kb == 2) en_b = d[0];
    end
    sel_a_n = 1'b1; sel_b_n = 1'b1; rnw = 1'b1;
    @(negedge clk);
    check({req, " R2 R11 page A"}, ra_a[15:8], pg_a);
    check({req, " R10 R11 page B"}, ra_b[15:8], pg_b);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 page A", ra_a[15:8], 8'h00);
    check("R1 page B", ra_b[15:8], 8'h00);
    bus_cycle(1'b1, 1'b0, 8'h40, 8'h00, 1'b1, "R1 disabled window");
    bus_cycle(1'b1, 1'b0, 8'h41, 8'h3C, 1'b0, "R5 write while disabled");
    // R2 / R10: page load
    bus_cycle(1'b0, 1'b1, 8'hFF, 8'h12, 1'b0, "R2 R10 page write");
    // R5: enable
    bus_cycle(1'b0, 1'b1, 8'hFE, 8'h01, 1'b0, "R5 enable");
    bus_cycle(1'b1, 1'b0, 8'h34, 8'h00, 1'b1, "R4 R7 window read");
    bus_cycle(1'b1, 1'b0, 8'h35, 8'hA5, 1'b0, "R6 window write");
    // R3 / R11: reading the page location
    bus_cycle(1'b0, 1'b1, 8'hFF, 8'h77, 1'b1, "R3 R11 page read");
    // R13: other control offsets
    bus_cycle(1'b0, 1'b1, 8'h10, 8'h00, 1'b0, "R13 stray write");
    bus_cycle(1'b0, 1'b1, 8'hFD, 8'h5E, 1'b0, "R13 stray write 2");
    // R9: reserved offsets; R8: mirror
    bus_cycle(1'b1, 1'b0, 8'hFE, 8'h00, 1'b1, "R9 reserved read");
    bus_cycle(1'b1, 1'b0, 8'hFF, 8'h00, 1'b1, "R8 R9 mirror read");
    bus_cycle(1'b1, 1'b0, 8'hFF, 8'h05, 1'b0, "R8 mirror write");
    bus_cycle(1'b1, 1'b0, 8'hFE, 8'h22, 1'b0, "R9 reserved write");
    // R12: both strobes
    bus_cycle(1'b0, 1'b0, 8'hFF, 8'h6B, 1'b0, "R12 both selects");
    bus_cycle(1'b0, 1'b0, 8'h20, 8'h00, 1'b1, "R12 both selects read");
    // R5: disable again, then re-enable
    bus_cycle(1'b0, 1'b1, 8'hFE, 8'hFE, 1'b0, "R5 disable");
    bus_cycle(1'b1, 1'b0, 8'h50, 8'h00, 1'b1, "R5 disabled read");
    bus_cycle(1'b0, 1'b1, 8'hFE, 8'h03, 1'b0, "R5 reenable");
    // random mix weighted toward special offsets
    for (int i = 0; i < 400; i++) begin
      logic sa, sb, rd;
      logic [7:0] a;
      int r;
      r  = int'($urandom_range(0, 9));
      sa = (r < 4) ? 1'b0 : 1'b1;
      sb = (r >= 3) ? 1'b0 : 1'b1;
      a  = ($urandom_range(0, 1) == 0) ? (8'hFE | 8'($urandom_range(0, 1)))
                                        : 8'($urandom);
      rd = 1'($urandom);
      bus_cycle(sa, sb, a, 8'($urandom), rd, "R2 R4 R6 R7 R12 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule